// File: doc/BRIEF.md
# NOR Flash Status Polling Responder

This block is the read-side responder of a parallel NOR flash device. It sits between the array read path and the 8-bit data bus. While the internal controller is programming or erasing, a read returns a status byte instead of stored data. The status byte carries a data-polling bit on bit 7 and a toggle bit on bit 6, so host software can tell when an operation has finished or when an erase has been suspended.

The controller state, the byte being programmed and an "address is inside the erasing block" flag come from the rest of the device. The read strobe `rd_en` is a plain level: a read completes on its falling edge. The bus output is combinational from the current inputs and two small state registers. There is no back-pressure. A read is served in the cycle it is presented.

Entering erase suspend is not instant. For `SUSP_LAT` clock cycles after the controller reports the suspend state, the block keeps answering as if the erase were still running.

Top module: `flash_status_responder`

## Requirements
- R1: With `op_mode` = 2'b00 (idle), `dq_out` equals `array_data` and `dq_is_status` is 0.
- R2: With `op_mode` = 2'b01 (program) or 2'b10 (erase), every read returns status (`dq_is_status` = 1), whatever the value of `in_erase_blk`.
- R3: During program, status bit 7 is the inverse of `prog_byte[7]`.
- R4: During erase, status bit 7 is 0.
- R5: During program and erase, status bit 6 inverts after each falling edge of `rd_en`, at any address.
- R6: For the first `SUSP_LAT` cycles with `op_mode` = 2'b11 (suspend), reads at any address return erase status: bit 7 is 0 and bit 6 keeps inverting per read.
- R7: Once suspend has taken effect, a read with `in_erase_blk` = 1 returns status with bit 7 = 1, and bit 6 holds its value across reads.
- R8: Once suspend has taken effect, a read with `in_erase_blk` = 0 returns `array_data` with `dq_is_status` = 0.
- R9: In any status byte, bits 5 to 0 are 0.
- R10: Idle clears the toggle bit, so the first status read of a new operation shows bit 6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 2 | Controller state: 00 idle, 01 program, 10 erase, 11 erase suspend |
| prog_byte | input | 8 | Byte being programmed |
| in_erase_blk | input | 1 | Read address lies inside the block under erase |
| rd_en | input | 1 | Read strobe; a read completes on its falling edge |
| array_data | input | 8 | Data read from the array |
| dq_out | output | 8 | Bus data: array data or status byte |
| dq_is_status | output | 1 | High when `dq_out` carries status |

## Verification
Program reads use bytes whose bit 7 is 1 and 0, so an inverted polling bit can be told from a copied one. Erase reads alternate between in-block and out-of-block addresses, which shows that the toggle does not depend on the address. Suspend is read both inside the latency window and after it, in and out of the erasing block. This separates erase-pending status, suspended status and array pass-through. A fresh program operation after an idle gap shows whether the toggle bit is cleared.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_PROG  = 2'b01,
    MODE_ERASE = 2'b10,
    MODE_SUSP  = 2'b11
  } op_mode_e;

  localparam int DQ_W = 8;
endpackage

// File: rtl/fsr_susp_timer.sv
`timescale 1ns/1ps
module fsr_susp_timer #(
  parameter int SUSP_LAT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fsr_pkg::op_mode_e   mode,
  output logic                suspended
);
  localparam int CW = $clog2(SUSP_LAT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SUSP_LAT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (mode != fsr_pkg::MODE_SUSP) cnt <= '0;
    else if (cnt != LIMIT)               cnt <= cnt + 1'b1;
  end

  assign suspended = (mode == fsr_pkg::MODE_SUSP) && (cnt == LIMIT);

  // R6
  susp_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != fsr_pkg::MODE_SUSP) |=> (cnt == '0));
endmodule

// File: rtl/fsr_toggle.sv
`timescale 1ns/1ps
module fsr_toggle (
  input  logic              clk,
  input  logic              rst_n,
  input  fsr_pkg::op_mode_e mode,
  input  logic              rd_en,
  input  logic              suspended,
  output logic              tog
);
  logic rd_q;
  logic rd_fall;
  logic busy;

  assign rd_fall = rd_q & ~rd_en;
  assign busy    = (mode == fsr_pkg::MODE_PROG) || (mode == fsr_pkg::MODE_ERASE) ||
                   ((mode == fsr_pkg::MODE_SUSP) && !suspended);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tog  <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (mode == fsr_pkg::MODE_IDLE) tog <= 1'b0;
      else if (busy && rd_fall)       tog <= ~tog;
    end
  end

  // R10
  idle_clears_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == fsr_pkg::MODE_IDLE) |=> !tog);
  // R7
  frozen_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == fsr_pkg::MODE_SUSP && suspended) |=> $stable(tog));
endmodule

// File: rtl/fsr_out_mux.sv
`timescale 1ns/1ps
module fsr_out_mux (
  input  logic                     clk,
  input  logic                     rst_n,
  input  fsr_pkg::op_mode_e        mode,
  input  logic                     suspended,
  input  logic                     in_erase_blk,
  input  logic                     tog,
  input  logic [fsr_pkg::DQ_W-1:0] prog_byte,
  input  logic [fsr_pkg::DQ_W-1:0] array_data,
  output logic [fsr_pkg::DQ_W-1:0] dq_out,
  output logic                     dq_is_status
);
  localparam int W = fsr_pkg::DQ_W;
  logic poll_bit;

  always_comb begin
    unique case (mode)
      fsr_pkg::MODE_IDLE:  begin dq_is_status = 1'b0; poll_bit = 1'b0; end
      fsr_pkg::MODE_PROG:  begin dq_is_status = 1'b1; poll_bit = ~prog_byte[W-1]; end
      fsr_pkg::MODE_ERASE: begin dq_is_status = 1'b1; poll_bit = 1'b0; end
      default: begin
        dq_is_status = !suspended || in_erase_blk;
        poll_bit     = suspended;
      end
    endcase
    dq_out = dq_is_status ? {poll_bit, tog, {(W-2){1'b0}}} : array_data;
  end

  // R9
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_is_status |-> (dq_out[W-3:0] == '0));
  // R1
  idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == fsr_pkg::MODE_IDLE) |-> (dq_out == array_data));
  // R3
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == fsr_pkg::MODE_PROG) |-> (dq_out[W-1] != prog_byte[W-1]));
endmodule

// File: rtl/flash_status_responder.sv
`timescale 1ns/1ps
module flash_status_responder #(
  parameter int SUSP_LAT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] op_mode,
  input  logic [7:0] prog_byte,
  input  logic       in_erase_blk,
  input  logic       rd_en,
  input  logic [7:0] array_data,
  output logic [7:0] dq_out,
  output logic       dq_is_status
);
  fsr_pkg::op_mode_e mode;
  logic suspended;
  logic tog;

  assign mode = fsr_pkg::op_mode_e'(op_mode);

  fsr_susp_timer #(.SUSP_LAT(SUSP_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .suspended(suspended));

  fsr_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_en(rd_en),
    .suspended(suspended), .tog(tog));

  fsr_out_mux u_mux (
    .clk(clk), .rst_n(rst_n), .mode(mode), .suspended(suspended),
    .in_erase_blk(in_erase_blk), .tog(tog), .prog_byte(prog_byte),
    .array_data(array_data), .dq_out(dq_out), .dq_is_status(dq_is_status));

  // R2
  busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == fsr_pkg::MODE_PROG || mode == fsr_pkg::MODE_ERASE) |-> dq_is_status);
endmodule

// File: tb/sim_flash_status_responder.sv
`timescale 1ns/1ps
module sim_flash_status_responder;
  localparam int SL = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_mode = 2'b00;
  logic [7:0] prog_byte = 8'h00;
  logic       in_erase_blk = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] array_data = 8'h00;
  logic [7:0] dq_out;
  logic       dq_is_status;

  int checks = 0;
  int errors = 0;
  logic exp_tog = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_responder #(.SUSP_LAT(SL)) u0 (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .prog_byte(prog_byte),
    .in_erase_blk(in_erase_blk), .rd_en(rd_en), .array_data(array_data),
    .dq_out(dq_out), .dq_is_status(dq_is_status));

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full read: strobe high for one cycle, sample, then release.
  task automatic do_read(input logic blk, input logic [7:0] arr, output logic [8:0] got);
    @(negedge clk);
    in_erase_blk = blk;
    array_data   = arr;
    rd_en        = 1'b1;
    @(negedge clk);
    got = {dq_is_status, dq_out};
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_reset;
    logic [8:0] g;
    @(negedge clk);
    array_data = 8'h5A;
    #1 chk("R1 reset", {dq_is_status, dq_out}, {1'b0, 8'h5A});
    do_read(1'b1, 8'hC3, g);
    chk("R1 idle read", g, {1'b0, 8'hC3});
  endtask

  task automatic test_program;
    logic [8:0] g;
    @(negedge clk);
    op_mode = 2'b01; prog_byte = 8'h80; exp_tog = 1'b0;
    do_read(1'b0, 8'hFF, g);
    chk("R3 R9 R10 prog first", g, {1'b1, 1'b0, exp_tog, 6'b0});
    exp_tog = ~exp_tog;
    do_read(1'b1, 8'hFF, g);
    chk("R2 R5 prog second", g, {1'b1, 1'b0, exp_tog, 6'b0});
    exp_tog = ~exp_tog;
    prog_byte = 8'h3C;
    do_read(1'b0, 8'h00, g);
    chk("R3 R5 prog bit7 clear", g, {1'b1, 1'b1, exp_tog, 6'b0});
    exp_tog = ~exp_tog;
    @(negedge clk);
    op_mode = 2'b00;
    do_read(1'b0, 8'h3C, g);
    chk("R1 done true data", g, {1'b0, 8'h3C});
    exp_tog = 1'b0;
  endtask

  task automatic test_erase;
    logic [8:0] g;
    @(negedge clk);
    op_mode = 2'b10;
    for (int i = 0; i < 4; i++) begin
      do_read(i[0], 8'hA5, g);
      chk("R2 R4 R5 erase", g, {1'b1, 1'b0, exp_tog, 6'b0});
      exp_tog = ~exp_tog;
    end
  endtask

  task automatic test_suspend;
    logic [8:0] g;
    logic       held;
    @(negedge clk);
    op_mode = 2'b11;
    do_read(1'b0, 8'h77, g);
    chk("R6 pending outside", g, {1'b1, 1'b0, exp_tog, 6'b0});
    exp_tog = ~exp_tog;
    repeat (SL + 2) @(negedge clk);
    held = exp_tog;
    do_read(1'b1, 8'h77, g);
    chk("R7 suspended in block", g, {1'b1, 1'b1, held, 6'b0});
    do_read(1'b1, 8'h77, g);
    chk("R7 toggle frozen", g, {1'b1, 1'b1, held, 6'b0});
    do_read(1'b0, 8'h69, g);
    chk("R8 suspended outside", g, {1'b0, 8'h69});
    @(negedge clk);
    op_mode = 2'b10;
    do_read(1'b0, 8'h00, g);
    chk("R4 R5 resume erase", g, {1'b1, 1'b0, held, 6'b0});
  endtask

  task automatic test_idle_clear;
    logic [8:0] g;
    @(negedge clk);
    op_mode = 2'b00;
    repeat (2) @(negedge clk);
    op_mode = 2'b01; prog_byte = 8'h01;
    do_read(1'b0, 8'h00, g);
    chk("R10 fresh op bit6", g, {1'b1, 1'b1, 1'b0, 6'b0});
    @(negedge clk);
    op_mode = 2'b00;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_program();
        test_erase();
        test_suspend();
        test_idle_clear();
      end
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule